// File: doc/BRIEF.md
# Host Parallel Register Port

This block is the slave side of a parallel host bus. An external microcontroller uses it to read and write 16-bit registers inside the chip. The host drives a data strobe, a transfer-size select, a read/write direction, a register address and 16 bits of write data. The block returns 16 bits of read data. The strobe and the size select each have a polarity chosen by a control bit. When a control bit is 0, its input is active low.

The strobe is brought into the core clock domain through a two-flop synchronizer. The block performs one internal register access for each assertion edge of the strobe. A 16-bit transaction is a single strobe. A 32-bit transaction is two strobes in a row. The first strobe uses the address and direction the host presents. The second strobe reuses that direction and uses the address plus one, whatever the host drives at that time. Toward the register file the block issues one-cycle write and read pulses with an address and write data. It takes the returned read data on the following clock edge and holds it for the host.

Top module: `host_reg_port`

## Requirements
- R1: After reset, reg_we and reg_re are 0 and host_rdata is 0.
- R2: Each assertion edge of the strobe produces exactly one one-cycle pulse on reg_we or reg_re. Holding the strobe active produces no further pulses. reg_we and reg_re are never high together.
- R3: For a write (host_rd = 0), reg_we is high for the clock cycle that starts at the third rising edge after the strobe becomes active. In that cycle reg_addr holds the access address and reg_wdata holds host_wdata.
- R4: For a read (host_rd = 1), reg_re pulses with the same timing as R3 and reg_addr holds the access address. On the next rising edge, host_rdata loads reg_rdata. host_rdata holds that value until the next read, and writes do not change it.
- R5: With strb_pol = 0 the strobe is active when host_strb is 0. With strb_pol = 1 it is active when host_strb is 1.
- R6: With size_pol = 0, host_size = 0 selects a 32-bit transaction. With size_pol = 1, host_size = 1 selects a 32-bit transaction. The other level selects 16-bit.
- R7: In a 32-bit transaction, the second strobe accesses the first strobe's address plus one and uses the first strobe's direction. The host_addr and host_rd values driven during the second strobe are ignored.
- R8: In 16-bit mode, every strobe accesses host_addr. Whenever the size select indicates 16-bit, even between strobes, the next 32-bit strobe is treated as a first half.
- R9: The second-half address wraps modulo 2^AW, so a first-half address of all ones is followed by address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| strb_pol | input | 1 | Strobe polarity: 1 selects active high, 0 selects active low |
| size_pol | input | 1 | Size-select polarity: 1 selects active high, 0 selects active low |
| host_strb | input | 1 | Host data strobe (asynchronous) |
| host_size | input | 1 | Host transfer size; the active level means 32-bit |
| host_rd | input | 1 | Direction: 1 for read, 0 for write |
| host_addr | input | AW | Register address from the host |
| host_wdata | input | DW | Write data from the host |
| host_rdata | output | DW | Read data returned to the host |
| reg_we | output | 1 | One-cycle write pulse to the register file |
| reg_re | output | 1 | One-cycle read pulse to the register file |
| reg_addr | output | AW | Register file address |
| reg_wdata | output | DW | Register file write data |
| reg_rdata | input | DW | Register file read data, valid while reg_re is high |

## Verification
If the half-transaction state is wrong, it shows on the very next strobe: reg_addr carries the host address where base plus one was due, or the reverse, and a second half can pulse the wrong one of reg_we and reg_re. A fault in the edge detector shows within three clocks of a strobe change, as a missing, repeated or mistimed pulse. A fault in the read-data register shows the cycle after reg_re, or as a value that changes after a write. The bench samples every access at its exact pulse cycle and at the cycle after it, so each of these faults is caught at the first transaction that exposes it.

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_pol,
  input  logic          size_pol,
  input  logic          host_strb,
  input  logic          host_size,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          reg_we,
  output logic          reg_re,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);

  logic          strb_act, size32, fire, second, rd_now;
  logic [2:0]    sync_q;
  logic          beat_q, dir_q;
  logic [AW-1:0] base_q, addr_now;

  assign strb_act = strb_pol ? host_strb : ~host_strb;
  assign size32   = size_pol ? host_size : ~host_size;
  assign fire     = sync_q[1] & ~sync_q[2];
  assign second   = size32 & beat_q;
  assign rd_now   = second ? dir_q : host_rd;
  assign addr_now = second ? base_q + AW'(1) : host_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      beat_q     <= 1'b0;
      dir_q      <= 1'b0;
      base_q     <= '0;
      reg_we     <= 1'b0;
      reg_re     <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      host_rdata <= '0;
    end else begin
      sync_q <= {sync_q[1:0], strb_act};
      reg_we <= fire & ~rd_now;
      reg_re <= fire & rd_now;
      if (fire) begin
        reg_addr  <= addr_now;
        reg_wdata <= host_wdata;
      end
      if (!size32) begin
        beat_q <= 1'b0;
      end else if (fire) begin
        beat_q <= ~beat_q;
        if (!beat_q) begin
          base_q <= host_addr;
          dir_q  <= host_rd;
        end
      end
      if (reg_re) host_rdata <= reg_rdata;
    end
  end

endmodule

// File: rtl/host_reg_port_chk.sv
module host_reg_port_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic          reg_re,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_rdata,
  input logic [DW-1:0] host_rdata,
  input logic          beat_q
);

  logic          pend_q;
  logic [AW-1:0] last_q;
  logic          acc;

  assign acc = reg_we | reg_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      last_q <= '0;
    end else if (acc) begin
      pend_q <= beat_q;
      last_q <= reg_addr;
    end else begin
      pend_q <= pend_q & beat_q;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> !reg_we && !reg_re);

  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n) acc |=> !acc);

  p_rdata_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> host_rdata == $past(reg_rdata));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(host_rdata));

  p_second_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && pend_q && !beat_q |-> reg_addr == last_q + AW'(1));

endmodule

bind host_reg_port host_reg_port_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .host_rdata(host_rdata),
  .beat_q(beat_q)
);

// File: tb/host_reg_port_tb.sv
`timescale 1ns/1ps
module host_reg_port_tb;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strb_pol = 1'b0, size_pol = 1'b0;
  logic host_strb = 1'b1, host_size = 1'b1, host_rd = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata, reg_wdata, reg_rdata;
  logic reg_we, reg_re;
  logic [AW-1:0] reg_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
    return {8'hC5, a} ^ 16'h0F0F;
  endfunction
  assign reg_rdata = model(reg_addr);

  host_reg_port #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .strb_pol(strb_pol), .size_pol(size_pol),
    .host_strb(host_strb), .host_size(host_size), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic act_lvl(input logic on);
    return strb_pol ? on : ~on;
  endfunction

  function automatic logic size_lvl(input logic on);
    return size_pol ? on : ~on;
  endfunction

  task automatic access(input logic rd, input logic sz, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic exp_rd,
                        input logic [AW-1:0] exp_a, input string tag);
    logic [DW-1:0] prev;
    prev = host_rdata;
    @(negedge clk);
    host_rd = rd; host_size = size_lvl(sz); host_addr = a; host_wdata = d;
    host_strb = act_lvl(1'b1);
    @(negedge clk);
    chk(!reg_we && !reg_re, {tag, " R3 no early pulse"}, {reg_we, reg_re}, 0);
    repeat (2) @(negedge clk);
    chk(reg_we == !exp_rd && reg_re == exp_rd, {tag, " R2 pulse kind"}, {reg_we, reg_re}, {!exp_rd, exp_rd});
    chk(reg_addr == exp_a, {tag, " R7 address"}, reg_addr, exp_a);
    if (!exp_rd) chk(reg_wdata == d, {tag, " R3 write data"}, reg_wdata, d);
    @(negedge clk);
    chk(!reg_we && !reg_re, {tag, " R2 single pulse"}, {reg_we, reg_re}, 0);
    if (exp_rd) chk(host_rdata == model(exp_a), {tag, " R4 read data"}, host_rdata, model(exp_a));
    else chk(host_rdata == prev, {tag, " R4 hold on write"}, host_rdata, prev);
    repeat (3) begin
      @(negedge clk);
      chk(!reg_we && !reg_re, {tag, " R2 held strobe"}, {reg_we, reg_re}, 0);
    end
    host_strb = act_lvl(1'b0);
    repeat (4) begin
      @(negedge clk);
      chk(!reg_we && !reg_re, {tag, " R2 release"}, {reg_we, reg_re}, 0);
    end
  endtask

  typedef struct packed {
    logic          rd;
    logic          sz;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          exp_rd;
    logic [AW-1:0] exp_addr;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 8'h10, 16'h1234, 1'b0, 8'h10},
    '{1'b1, 1'b0, 8'h22, 16'h0000, 1'b1, 8'h22},
    '{1'b0, 1'b1, 8'h40, 16'hAAAA, 1'b0, 8'h40},
    '{1'b1, 1'b1, 8'h77, 16'hBBBB, 1'b0, 8'h41},
    '{1'b1, 1'b1, 8'h50, 16'h0000, 1'b1, 8'h50},
    '{1'b0, 1'b1, 8'h03, 16'h5555, 1'b1, 8'h51},
    '{1'b0, 1'b1, 8'hFF, 16'hC0DE, 1'b0, 8'hFF},
    '{1'b0, 1'b1, 8'h00, 16'hBEEF, 1'b0, 8'h00}
  };

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!reg_we && !reg_re, "R1 reset pulses", {reg_we, reg_re}, 0);
    chk(host_rdata == '0, "R1 reset rdata", host_rdata, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!reg_we && !reg_re, "R1 idle after reset", {reg_we, reg_re}, 0);

    for (int i = 0; i < 8; i++)
      access(VEC[i].rd, VEC[i].sz, VEC[i].addr, VEC[i].data, VEC[i].exp_rd,
             VEC[i].exp_addr, $sformatf("vec%0d R9", i));

    // R8: dropping to 16-bit between strobes restarts the pair
    access(1'b0, 1'b1, 8'h60, 16'h1111, 1'b0, 8'h60, "R8 first half");
    @(negedge clk); host_size = size_lvl(1'b0);
    repeat (2) @(negedge clk);
    access(1'b1, 1'b1, 8'h90, 16'h0000, 1'b1, 8'h90, "R8 restart");
    access(1'b1, 1'b1, 8'h11, 16'h0000, 1'b1, 8'h91, "R8 pair done");

    // R5: active-high strobe
    @(negedge clk); strb_pol = 1'b1; host_strb = 1'b0;
    repeat (4) @(negedge clk);
    chk(!reg_we && !reg_re, "R5 no access on polarity change", {reg_we, reg_re}, 0);
    access(1'b0, 1'b0, 8'h33, 16'h7777, 1'b0, 8'h33, "R5 high strobe");

    // R6: active-high size select
    @(negedge clk); size_pol = 1'b1; host_size = 1'b0;
    access(1'b1, 1'b1, 8'hA0, 16'h0000, 1'b1, 8'hA0, "R6 first");
    access(1'b0, 1'b1, 8'h05, 16'h0000, 1'b1, 8'hA1, "R6 second");
    access(1'b1, 1'b0, 8'h05, 16'h0000, 1'b1, 8'h05, "R6 sixteen");

    done = 1;
    finish_run();
  end
endmodule